// File: doc/BRIEF.md
# Single and Double Tap Detector

The block watches a stream of signed three-axis acceleration samples and reports short impacts. A tap is a burst in which at least one enabled axis rises above a programmable threshold and falls back within a programmable maximum width. After a first tap, a dead time runs out. Then a bounded window opens, and a second qualifying burst inside it is reported as a double tap.

All timing is measured by counting a free-running microsecond tick. Each timing field is compared against field × unit, so no per-field divider is needed. The block has a sticky per-axis source mask that records which axes took part in accepted taps. The host clears this mask with a strobe. Register access, interrupt routing and sample filtering live outside the block.

Top module: `tap_detect`

## Requirements
- R1: While reset is held and in the first cycle after reset, `single_tap` and `double_tap` are low and `tap_src` is zero.
- R2: An axis is over threshold when the absolute value of its signed 16-bit sample is strictly greater than `cfg_thresh` × 16. A magnitude equal to that product does not count. Negative samples are judged by their magnitude, and -32768 counts as 32768.
- R3: `cfg_axis_en` bit 0 enables X, bit 1 enables Y and bit 2 enables Z. A disabled axis never starts or extends a burst, and it never sets its `tap_src` bit.
- R4: Only cycles with `smp_valid` high take part in detection. Over-threshold values presented with `smp_valid` low produce no tap.
- R5: A burst starts on the first valid sample with an enabled axis over threshold. It ends on the first later valid sample with no enabled axis over. Count the ticks from the cycle after the start up to the ending sample. If that count is no more than `cfg_dur` × 625, `single_tap` pulses for exactly one cycle, in the cycle after the ending sample. Otherwise no tap is reported, and the block becomes idle once the burst ends.
- R6: `tap_src` bit 0 is X, bit 1 is Y and bit 2 is Z. The mask ORs in every enabled axis that was over threshold during an accepted burst, in the same cycle as the tap pulse. `src_clear` zeroes the mask. If a clear and a new set fall in the same cycle, the new bits are kept.
- R7: After a single tap, a dead time of `cfg_latency` × 1250 ticks follows. A burst that starts during the dead time cancels the double-tap attempt. That burst reports nothing, and the block returns to idle once it ends.
- R8: A burst that starts after the dead time, within `cfg_window` × 1250 ticks, and that qualifies under R5 produces one `double_tap` pulse and no second `single_tap`.
- R9: Once the window runs out with no burst, the block is idle. A later burst is judged as a new first tap.
- R10: If `cfg_latency` or `cfg_window` is zero, no `double_tap` is ever produced, and every qualifying burst gives a `single_tap`.
- R11: Timers advance only in cycles where `us_tick` is high. A burst of any length in cycles without ticks is still within its width limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| smp_valid | input | 1 | Sample strobe |
| smp_x | input | 16 | Signed X sample |
| smp_y | input | 16 | Signed Y sample |
| smp_z | input | 16 | Signed Z sample |
| cfg_thresh | input | 8 | Threshold, 16 sample LSBs per step |
| cfg_dur | input | 8 | Maximum burst width, 625 ticks per step |
| cfg_latency | input | 8 | Dead time after first tap, 1250 ticks per step |
| cfg_window | input | 8 | Second-tap window, 1250 ticks per step |
| cfg_axis_en | input | 3 | Axis enable mask {Z,Y,X} |
| src_clear | input | 1 | Clears the tap source mask |
| single_tap | output | 1 | Single-tap event pulse |
| double_tap | output | 1 | Double-tap event pulse |
| tap_src | output | 3 | Sticky tap source mask {Z,Y,X} |

## Verification
The bench targets four boundaries:
- The threshold equality point. A design that compares with greater-or-equal would report a tap on a sample exactly at the threshold.
- The width limit, one tick either side. An off-by-one timer would accept the overlong burst or reject the exact-limit burst.
- The three regions for the second burst: inside the dead time, inside the window, and after the window. A design that mixes up dead time and window would report a double tap where a cancel is due, or the reverse.
- A zero timing field, the most negative sample, and a stalled tick. A design with a wrong magnitude, a missing disable check, or a free-running timer would miss taps or report spurious doubles.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TAP1  = 3'd1,
    ST_LAT   = 3'd2,
    ST_WIN   = 3'd3,
    ST_TAP2  = 3'd4,
    ST_DRAIN = 3'd5
  } tap_state_e;

  typedef enum logic [1:0] {
    LIM_DUR = 2'd0,
    LIM_LAT = 2'd1,
    LIM_WIN = 2'd2
  } lim_sel_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tap_axis_cmp.sv
module tap_axis_cmp #(
  parameter int SAMPLE_W  = 16,
  parameter int CFG_W     = 8,
  parameter int THR_SHIFT = 4,
  parameter int N_AXES    = 3
) (
  input  logic [N_AXES*SAMPLE_W-1:0] samples,
  input  logic [CFG_W-1:0]           thresh,
  input  logic [N_AXES-1:0]          axis_en,
  output logic [N_AXES-1:0]          over
);
  localparam int THR_W = CFG_W + THR_SHIFT;
  localparam int CMP_W = (SAMPLE_W > THR_W) ? SAMPLE_W : THR_W;

  logic [CMP_W-1:0] thr_scaled;
  assign thr_scaled = CMP_W'(thresh) << THR_SHIFT;

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    logic [SAMPLE_W-1:0] raw;
    logic [SAMPLE_W-1:0] mag;
    assign raw = samples[g*SAMPLE_W +: SAMPLE_W];
    // Two's complement negate; the most negative code maps to its unsigned magnitude.
    assign mag = raw[SAMPLE_W-1] ? (~raw + 1'b1) : raw;
    assign over[g] = axis_en[g] && (CMP_W'(mag) > thr_scaled);
  end

endmodule

// File: rtl/tap_interval_timer.sv
module tap_interval_timer
  import tap_pkg::*;
#(
  parameter int          CFG_W    = 8,
  parameter int unsigned DUR_UNIT = 625,
  parameter int unsigned LAT_UNIT = 1250,
  parameter int unsigned WIN_UNIT = 1250,
  parameter int          TIMER_W  = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  lim_sel_e         sel,
  input  logic [CFG_W-1:0] cfg_dur,
  input  logic [CFG_W-1:0] cfg_lat,
  input  logic [CFG_W-1:0] cfg_win,
  output logic             past_limit,
  output logic             at_limit
);
  logic [TIMER_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;
  logic [TIMER_W-1:0] lim_dur, lim_lat, lim_win, limit;

  assign lim_dur = TIMER_W'(cfg_dur) * TIMER_W'(DUR_UNIT);
  assign lim_lat = TIMER_W'(cfg_lat) * TIMER_W'(LAT_UNIT);
  assign lim_win = TIMER_W'(cfg_win) * TIMER_W'(WIN_UNIT);

  always_comb begin
    unique case (sel)
      LIM_LAT: limit = lim_lat;
      LIM_WIN: limit = lim_win;
      default: limit = lim_dur;
    endcase
  end

  // Saturating tick counter, zeroed on each phase change.
  assign cnt_en = restart || (tick && (cnt_q != {TIMER_W{1'b1}}));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign past_limit = cnt_q > limit;
  assign at_limit   = cnt_q >= limit;

endmodule

// File: rtl/tap_seq_fsm.sv
module tap_seq_fsm
  import tap_pkg::*;
#(
  parameter int N_AXES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [N_AXES-1:0] over,
  input  logic              dbl_off,
  input  logic              past_limit,
  input  logic              at_limit,
  output lim_sel_e          sel,
  output logic              restart,
  output logic              accept,
  output logic [N_AXES-1:0] seen_axes,
  output logic              single_pulse,
  output logic              double_pulse
);
  tap_state_e        state_q, state_d;
  logic [N_AXES-1:0] seen_q, seen_d;
  logic              acc_single, acc_double;
  logic              hit, quiet;

  assign hit   = smp_valid && (|over);
  assign quiet = smp_valid && !(|over);

  always_comb begin
    state_d    = state_q;
    seen_d     = seen_q;
    acc_single = 1'b0;
    acc_double = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hit) begin
          state_d = ST_TAP1;
          seen_d  = over;
        end
      end
      ST_TAP1: begin
        if (hit) seen_d = seen_q | over;
        if (past_limit) begin
          state_d = quiet ? ST_IDLE : ST_DRAIN;
        end else if (quiet) begin
          acc_single = 1'b1;
          state_d    = dbl_off ? ST_IDLE : ST_LAT;
        end
      end
      ST_LAT: begin
        if (hit)           state_d = ST_DRAIN;
        else if (at_limit) state_d = ST_WIN;
      end
      ST_WIN: begin
        if (hit) begin
          state_d = ST_TAP2;
          seen_d  = over;
        end else if (at_limit) begin
          state_d = ST_IDLE;
        end
      end
      ST_TAP2: begin
        if (hit) seen_d = seen_q | over;
        if (past_limit) begin
          state_d = quiet ? ST_IDLE : ST_DRAIN;
        end else if (quiet) begin
          acc_double = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (quiet) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_LAT:  sel = LIM_LAT;
      ST_WIN:  sel = LIM_WIN;
      default: sel = LIM_DUR;
    endcase
  end

  assign restart   = state_d != state_q;
  assign accept    = acc_single || acc_double;
  assign seen_axes = seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      seen_q       <= '0;
      single_pulse <= 1'b0;
      double_pulse <= 1'b0;
    end else begin
      state_q      <= state_d;
      seen_q       <= seen_d;
      single_pulse <= acc_single;
      double_pulse <= acc_double;
    end
  end

  // R7: a burst inside the dead time cancels the attempt.
  p_lat_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LAT && hit) |=> (state_q == ST_DRAIN && !double_pulse));

  // R5: tap event is a single-cycle pulse.
  p_single_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    single_pulse |=> !single_pulse);

  // R5: a drained burst returns to idle on its first quiet sample.
  p_drain_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && quiet) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/tap_detect.sv
module tap_detect
  import tap_pkg::*;
#(
  parameter int          SAMPLE_W  = 16,
  parameter int          CFG_W     = 8,
  parameter int          THR_SHIFT = 4,
  parameter int unsigned DUR_UNIT  = 625,
  parameter int unsigned LAT_UNIT  = 1250,
  parameter int unsigned WIN_UNIT  = 1250
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                us_tick,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_x,
  input  logic [SAMPLE_W-1:0] smp_y,
  input  logic [SAMPLE_W-1:0] smp_z,
  input  logic [CFG_W-1:0]    cfg_thresh,
  input  logic [CFG_W-1:0]    cfg_dur,
  input  logic [CFG_W-1:0]    cfg_latency,
  input  logic [CFG_W-1:0]    cfg_window,
  input  logic [2:0]          cfg_axis_en,
  input  logic                src_clear,
  output logic                single_tap,
  output logic                double_tap,
  output logic [2:0]          tap_src
);
  localparam int          N_AXES   = 3;
  localparam int unsigned MAX_UNIT = max3(DUR_UNIT, LAT_UNIT, WIN_UNIT);
  localparam longint      MAX_LIM  = longint'((2**CFG_W) - 1) * longint'(MAX_UNIT);
  localparam int          TIMER_W  = $clog2(MAX_LIM + 2);

  logic [N_AXES-1:0] over;
  logic [N_AXES-1:0] seen_axes;
  logic              restart, accept, past_limit, at_limit, dbl_off;
  lim_sel_e          sel;
  logic [2:0]        src_q, src_d;
  logic              src_en;

  tap_axis_cmp #(
    .SAMPLE_W (SAMPLE_W),
    .CFG_W    (CFG_W),
    .THR_SHIFT(THR_SHIFT),
    .N_AXES   (N_AXES)
  ) i_cmp (
    .samples(({smp_z, smp_y, smp_x})),
    .thresh (cfg_thresh),
    .axis_en(cfg_axis_en),
    .over   (over)
  );

  tap_interval_timer #(
    .CFG_W   (CFG_W),
    .DUR_UNIT(DUR_UNIT),
    .LAT_UNIT(LAT_UNIT),
    .WIN_UNIT(WIN_UNIT),
    .TIMER_W (TIMER_W)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (us_tick),
    .restart   (restart),
    .sel       (sel),
    .cfg_dur   (cfg_dur),
    .cfg_lat   (cfg_latency),
    .cfg_win   (cfg_window),
    .past_limit(past_limit),
    .at_limit  (at_limit)
  );

  assign dbl_off = (cfg_latency == '0) || (cfg_window == '0);

  tap_seq_fsm #(
    .N_AXES(N_AXES)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .over        (over),
    .dbl_off     (dbl_off),
    .past_limit  (past_limit),
    .at_limit    (at_limit),
    .sel         (sel),
    .restart     (restart),
    .accept      (accept),
    .seen_axes   (seen_axes),
    .single_pulse(single_tap),
    .double_pulse(double_tap)
  );

  // Sticky source mask: a set in the same cycle as a clear is kept.
  assign src_en = src_clear || accept;

  always_comb begin
    src_d = src_clear ? 3'b000 : src_q;
    if (accept) src_d = src_d | seen_axes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_en) src_q <= src_d;
  end

  assign tap_src = src_q;

  // R6: a source bit only appears together with a tap pulse.
  p_src_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((tap_src & ~$past(tap_src)) != 3'b000) |-> (single_tap || double_tap));

  // R10: no double tap while either timing field is zero.
  p_dbl_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    double_tap |-> ($past(cfg_latency) != '0 && $past(cfg_window) != '0));

  // R8: the second tap is never also reported as a single tap.
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_tap && double_tap));

endmodule

// File: tb/test_tap_detect.sv
module test_tap_detect;

  logic        clk;
  logic        rst_n;
  logic        us_tick;
  logic        smp_valid;
  logic [15:0] smp_x, smp_y, smp_z;
  logic [7:0]  cfg_thresh, cfg_dur, cfg_latency, cfg_window;
  logic [2:0]  cfg_axis_en;
  logic        src_clear;
  logic        single_tap, double_tap;
  logic [2:0]  tap_src;

  int n_checks = 0;
  int n_fail   = 0;
  int n_sgl    = 0;
  int n_dbl    = 0;
  bit done     = 0;

  tap_detect i_tap_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .us_tick    (us_tick),
    .smp_valid  (smp_valid),
    .smp_x      (smp_x),
    .smp_y      (smp_y),
    .smp_z      (smp_z),
    .cfg_thresh (cfg_thresh),
    .cfg_dur    (cfg_dur),
    .cfg_latency(cfg_latency),
    .cfg_window (cfg_window),
    .cfg_axis_en(cfg_axis_en),
    .src_clear  (src_clear),
    .single_tap (single_tap),
    .double_tap (double_tap),
    .tap_src    (tap_src)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (single_tap) n_sgl++;
      if (double_tap) n_dbl++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present a sample for n clock cycles, starting from a falling edge.
  task automatic hold(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z,
                      input int n);
    smp_valid = 1'b1;
    smp_x = x; smp_y = y; smp_z = z;
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input int n);
    hold(16'd0, 16'd0, 16'd0, n);
  endtask

  task automatic start_case(input logic [7:0] lat, input logic [7:0] win);
    cfg_thresh  = 8'd16;
    cfg_dur     = 8'd1;
    cfg_latency = lat;
    cfg_window  = win;
    cfg_axis_en = 3'b111;
    us_tick     = 1'b1;
    quiet(3000);
    src_clear = 1'b1;
    @(negedge clk);
    src_clear = 1'b0;
    n_sgl = 0;
    n_dbl = 0;
  endtask

  task automatic t_reset;
    check("R1 single_tap after reset", int'(single_tap), 0);
    check("R1 double_tap after reset", int'(double_tap), 0);
    check("R1 tap_src after reset", int'(tap_src), 0);
  endtask

  task automatic t_threshold;
    start_case(8'd0, 8'd0);
    hold(16'd256, 16'd0, 16'd0, 5); quiet(10);
    check("R2 magnitude equal to threshold", n_sgl, 0);
    hold(16'd257, 16'd0, 16'd0, 5); quiet(10);
    check("R2 magnitude one above threshold", n_sgl, 1);
    check("R6 source X", int'(tap_src), 1);
    hold(16'd0, 16'h8000, 16'd0, 5); quiet(10);
    check("R2 most negative sample", n_sgl, 2);
    check("R6 source accumulates Y", int'(tap_src), 3);
    hold(16'd0, 16'd0, 16'hFEFF, 5); quiet(10);
    check("R2 negative Z -257", n_sgl, 3);
    check("R6 source accumulates Z", int'(tap_src), 7);
    check("R10 no double when latency zero", n_dbl, 0);
  endtask

  task automatic t_axis_enable;
    start_case(8'd0, 8'd0);
    cfg_axis_en = 3'b001;
    hold(16'd0, 16'd1000, 16'd1000, 5); quiet(10);
    check("R3 disabled axes ignored", n_sgl, 0);
    check("R3 disabled axes leave source clear", int'(tap_src), 0);
    hold(16'd1000, 16'd1000, 16'd0, 5); quiet(10);
    check("R3 enabled axis taps", n_sgl, 1);
    check("R3 only enabled axis recorded", int'(tap_src), 1);
    src_clear = 1'b1;
    @(negedge clk);
    src_clear = 1'b0;
    check("R6 source cleared", int'(tap_src), 0);
  endtask

  task automatic t_valid;
    start_case(8'd0, 8'd0);
    hold(16'd2000, 16'd0, 16'd0, 10);
    smp_valid = 1'b0;
    smp_x = 16'd0;
    quiet(10);
    // The over-threshold values above were valid; now repeat with strobe low.
    n_sgl = 0;
    smp_valid = 1'b0;
    smp_x = 16'd2000;
    repeat (10) @(negedge clk);
    quiet(10);
    check("R4 samples without strobe ignored", n_sgl, 0);
  endtask

  task automatic t_duration;
    start_case(8'd0, 8'd0);
    hold(16'd1000, 16'd0, 16'd0, 5);
    smp_x = 16'd0;
    @(negedge clk);
    check("R5 pulse in cycle after ending sample", int'(single_tap), 1);
    @(negedge clk);
    check("R5 pulse lasts one cycle", int'(single_tap), 0);
    quiet(10);
    n_sgl = 0;
    hold(16'd1000, 16'd0, 16'd0, 626); quiet(10);
    check("R5 burst at width limit accepted", n_sgl, 1);
    hold(16'd1000, 16'd0, 16'd0, 627); quiet(10);
    check("R5 burst one tick over limit rejected", n_sgl, 1);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(10);
    check("R5 idle again after rejected burst", n_sgl, 2);
  endtask

  task automatic t_double;
    start_case(8'd1, 8'd1);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(2000);
    hold(16'd0, 16'd0, 16'd1000, 5); quiet(3000);
    check("R8 double tap inside window", n_dbl, 1);
    check("R8 no second single tap", n_sgl, 1);
    check("R6 source records both taps", int'(tap_src), 5);
  endtask

  task automatic t_latency_cancel;
    start_case(8'd1, 8'd1);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(500);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(3000);
    check("R7 burst in dead time gives no double", n_dbl, 0);
    check("R7 burst in dead time gives no single", n_sgl, 1);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(10);
    check("R7 idle after cancel", n_sgl, 2);
  endtask

  task automatic t_window_expire;
    start_case(8'd1, 8'd1);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(4000);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(3000);
    check("R9 late burst is new single", n_sgl, 2);
    check("R9 late burst no double", n_dbl, 0);
  endtask

  task automatic t_dbl_off;
    start_case(8'd0, 8'd1);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(2000);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(3000);
    check("R10 latency zero gives two singles", n_sgl, 2);
    check("R10 latency zero gives no double", n_dbl, 0);
    start_case(8'd1, 8'd0);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(2000);
    hold(16'd1000, 16'd0, 16'd0, 5); quiet(3000);
    check("R10 window zero gives two singles", n_sgl, 2);
    check("R10 window zero gives no double", n_dbl, 0);
  endtask

  task automatic t_tick;
    start_case(8'd0, 8'd0);
    us_tick = 1'b0;
    hold(16'd1000, 16'd0, 16'd0, 2000); quiet(10);
    check("R11 timer frozen without tick", n_sgl, 1);
    us_tick = 1'b1;
  endtask

  initial begin
    rst_n       = 1'b0;
    us_tick     = 1'b1;
    smp_valid   = 1'b0;
    smp_x       = '0;
    smp_y       = '0;
    smp_z       = '0;
    cfg_thresh  = 8'd16;
    cfg_dur     = 8'd1;
    cfg_latency = 8'd0;
    cfg_window  = 8'd0;
    cfg_axis_en = 3'b111;
    src_clear   = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_axis_enable();
    t_valid();
    t_duration();
    t_double();
    t_latency_cancel();
    t_window_expire();
    t_dbl_off();
    t_tick();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      repeat (190000) @(posedge clk);
    join_any
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule